// File: doc/BRIEF.md
# Locality Claim and Release Sequencer

This controller opens and closes locality 0 of a trusted-module register window by driving a simple memory-mapped master port. An open request is handled in a fixed order. The sequencer reads the identity word and compares it with a configured value. On a match it writes a use request into the access register. It then polls the access register until the active-locality bit is set. Finally it writes the command-ready code into the status register and raises `ready`. A close request reads the access register first. If the locality is held, the sequencer writes the relinquish code and polls until the active bit clears. If the locality is not held, it finishes after that single read and writes nothing.

Every poll loop is limited to `MAX_POLLS` reads, spaced by `POLL_GAP` clock cycles. With the defaults this is one million reads, about 1 µs apart at 50 MHz. A loop that runs out of reads raises `err_timeout`. A wrong identity word raises `err_nodev`. All result flags hold until the next accepted request.

The states are IDLE, ID_RD, REQ_WR, GRANT_RD, GRANT_GAP, CMD_WR, CHK_RD, REL_WR, REL_RD and REL_GAP. The transitions are as follows:
- IDLE→ID_RD on open.
- IDLE→CHK_RD on close.
- ID_RD→REQ_WR on a match.
- ID_RD→IDLE on a mismatch.
- REQ_WR→GRANT_RD.
- GRANT_RD→CMD_WR when granted.
- GRANT_RD→GRANT_GAP on a miss.
- GRANT_RD→IDLE on exhaustion.
- GRANT_GAP→GRANT_RD.
- CMD_WR→IDLE.
- CHK_RD→REL_WR when held.
- CHK_RD→IDLE when free.
- REL_WR→REL_RD.
- REL_RD→IDLE when cleared or on exhaustion.
- REL_RD→REL_GAP on a miss.
- REL_GAP→REL_RD.

Top module: `tis_locality_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `ready`, `err_nodev`, `err_timeout` and `m_req` are all 0.
- R2: An open first reads the identity word at `REG_BASE+0xF00`, a 32-bit value with the vendor ID in bits 15:0 and the device ID in bits 31:16. If the word differs from `EXPECTED_ID`, `err_nodev` is set and no other bus access follows.
- R3: When the identity matches, the next access is a write of 0x02 to the access register at `REG_BASE+0x00`.
- R4: The sequencer reads the access register until bit 5 reads 1. It then writes 0x40 to the status register at `REG_BASE+0x18`, and when that write is acknowledged it sets `ready`.
- R5: Two successive reads within one poll loop are separated by at least `POLL_GAP` idle cycles.
- R6: If `MAX_POLLS` reads in a loop never show the awaited bit 5 value, `err_timeout` is set and the operation ends without any further write.
- R7: A close that reads access bit 5 as 1 writes 0x20 to the access register. It then reads the access register until bit 5 reads 0 and clears `ready`.
- R8: A close that reads access bit 5 as 0 ends after that one read, with no write.
- R9: Requests that arrive while `busy` is 1 are ignored. If `open_req` and `close_req` are both 1 in the idle state, the open is performed.
- R10: `ready`, `err_nodev` and `err_timeout` hold their values until the next accepted request. At most one of them is 1 at any time.
- R11: `m_req`, `m_we`, `m_addr` and `m_wdata` stay constant from the start of a transfer until `m_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| open_req | input | 1 | Start an open (claim) sequence |
| close_req | input | 1 | Start a close (release) sequence |
| busy | output | 1 | A sequence is in progress |
| ready | output | 1 | Locality held and command-ready written |
| err_nodev | output | 1 | Identity word mismatch |
| err_timeout | output | 1 | A poll loop ran out of reads |
| m_req | output | 1 | Bus transfer request |
| m_we | output | 1 | Transfer is a write |
| m_addr | output | ADDR_W | Byte address |
| m_wdata | output | DATA_W | Write data (0 on reads) |
| m_ack | input | 1 | Transfer complete; read data valid |
| m_rdata | input | DATA_W | Read data |

## Verification
On every cycle the assertions check the following:
- the bus request stays stable until it is acknowledged;
- no request is made while the block is idle;
- only the three legal codes are ever written;
- the result flags are mutually exclusive;
- each flag rises only right after the acknowledged access that justifies it.

The order of the transfers is a property of a whole scenario, so only the bench's scenarios can show it. The same holds for the number of poll reads before a grant or a timeout, the spacing between polls, the single read of a close on a free locality, and the dropping of requests that arrive while busy. The bench shows these by running a device model with a programmable grant delay and release delay against a predicted transfer list.

// File: rtl/tis_locality_pkg.sv
package tis_locality_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID_RD,
        ST_REQ_WR,
        ST_GRANT_RD,
        ST_GRANT_GAP,
        ST_CMD_WR,
        ST_CHK_RD,
        ST_REL_WR,
        ST_REL_RD,
        ST_REL_GAP
    } seq_state_t;

    localparam int unsigned ACTIVE_BIT   = 5;
    localparam int unsigned OFS_ACCESS   = 'h000;
    localparam int unsigned OFS_STATUS   = 'h018;
    localparam int unsigned OFS_IDENT    = 'hF00;
    localparam int unsigned WIN_BYTES    = 'h1000;

    localparam logic [7:0] CODE_USE      = 8'h02;
    localparam logic [7:0] CODE_RELEASE  = 8'h20;
    localparam logic [7:0] CODE_CMDRDY   = 8'h40;

endpackage

// File: rtl/tis_field_match.sv
module tis_field_match #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] pattern,
    output logic         hit
);
    always_comb begin
        hit = ((value & mask) == (pattern & mask));
    end
endmodule

// File: rtl/tis_poll_pacer.sv
module tis_poll_pacer #(
    parameter int unsigned POLL_GAP  = 50,
    parameter int unsigned MAX_POLLS = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic miss,
    output logic last_poll,
    output logic gap_done
);
    localparam int unsigned CNT_W = $clog2(MAX_POLLS + 1);
    localparam int unsigned GAP_W = $clog2(POLL_GAP + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_POLLS - 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(POLL_GAP);

    logic [CNT_W-1:0] polls_done;
    logic [GAP_W-1:0] gap_left;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            polls_done <= '0;
            gap_left   <= '0;
        end else if (miss) begin
            polls_done <= polls_done + 1'b1;
            gap_left   <= GAP_LOAD;
        end else if (gap_left != '0) begin
            gap_left   <= gap_left - 1'b1;
        end
    end

    always_comb begin
        last_poll = (polls_done == LAST_IDX);
        gap_done  = (gap_left == GAP_W'(1)) || (gap_left == '0);
    end
endmodule

// File: rtl/tis_locality_ctrl.sv
module tis_locality_ctrl
    import tis_locality_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned REG_BASE    = 0,
    parameter logic [31:0] EXPECTED_ID = 32'h0001_5D1B,
    parameter int unsigned POLL_GAP    = 50,
    parameter int unsigned MAX_POLLS   = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_req,
    input  logic              close_req,
    output logic              busy,
    output logic              ready,
    output logic              err_nodev,
    output logic              err_timeout,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_ack,
    input  logic [DATA_W-1:0] m_rdata
);
    localparam int unsigned      LOC0_BASE = REG_BASE + 0 * WIN_BYTES;
    localparam logic [ADDR_W-1:0] A_ACCESS = ADDR_W'(LOC0_BASE + OFS_ACCESS);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(LOC0_BASE + OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(LOC0_BASE + OFS_IDENT);
    localparam logic [DATA_W-1:0] ACT_MASK = DATA_W'(1) << ACTIVE_BIT;
    localparam logic [DATA_W-1:0] ID_WORD  = DATA_W'(EXPECTED_ID);

    seq_state_t state;

    logic id_hit;
    logic active_seen;
    logic pacer_clear;
    logic pacer_miss;
    logic last_poll;
    logic gap_done;

    tis_field_match #(.W(DATA_W)) u_id_match (
        .value   (m_rdata),
        .mask    ({DATA_W{1'b1}}),
        .pattern (ID_WORD),
        .hit     (id_hit)
    );

    tis_field_match #(.W(DATA_W)) u_active_match (
        .value   (m_rdata),
        .mask    (ACT_MASK),
        .pattern (ACT_MASK),
        .hit     (active_seen)
    );

    tis_poll_pacer #(
        .POLL_GAP  (POLL_GAP),
        .MAX_POLLS (MAX_POLLS)
    ) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (pacer_clear),
        .miss      (pacer_miss),
        .last_poll (last_poll),
        .gap_done  (gap_done)
    );

    // State register and held result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            ready       <= 1'b0;
            err_nodev   <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (open_req || close_req) begin
                        ready       <= 1'b0;
                        err_nodev   <= 1'b0;
                        err_timeout <= 1'b0;
                        state       <= open_req ? ST_ID_RD : ST_CHK_RD;
                    end
                end
                ST_ID_RD: begin
                    if (m_ack) begin
                        if (id_hit) begin
                            state <= ST_REQ_WR;
                        end else begin
                            err_nodev <= 1'b1;
                            state     <= ST_IDLE;
                        end
                    end
                end
                ST_REQ_WR: begin
                    if (m_ack) state <= ST_GRANT_RD;
                end
                ST_GRANT_RD: begin
                    if (m_ack) begin
                        if (active_seen) begin
                            state <= ST_CMD_WR;
                        end else if (last_poll) begin
                            err_timeout <= 1'b1;
                            state       <= ST_IDLE;
                        end else begin
                            state <= ST_GRANT_GAP;
                        end
                    end
                end
                ST_GRANT_GAP: begin
                    if (gap_done) state <= ST_GRANT_RD;
                end
                ST_CMD_WR: begin
                    if (m_ack) begin
                        ready <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_CHK_RD: begin
                    if (m_ack) state <= active_seen ? ST_REL_WR : ST_IDLE;
                end
                ST_REL_WR: begin
                    if (m_ack) state <= ST_REL_RD;
                end
                ST_REL_RD: begin
                    if (m_ack) begin
                        if (!active_seen) begin
                            state <= ST_IDLE;
                        end else if (last_poll) begin
                            err_timeout <= 1'b1;
                            state       <= ST_IDLE;
                        end else begin
                            state <= ST_REL_GAP;
                        end
                    end
                end
                ST_REL_GAP: begin
                    if (gap_done) state <= ST_REL_RD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus and pacer outputs decoded from state
    always_comb begin
        m_req       = 1'b0;
        m_we        = 1'b0;
        m_addr      = '0;
        m_wdata     = '0;
        pacer_clear = 1'b0;
        pacer_miss  = 1'b0;
        busy        = (state != ST_IDLE);
        unique case (state)
            ST_IDLE: begin
            end
            ST_ID_RD: begin
                m_req  = 1'b1;
                m_addr = A_IDENT;
            end
            ST_REQ_WR: begin
                m_req       = 1'b1;
                m_we        = 1'b1;
                m_addr      = A_ACCESS;
                m_wdata     = DATA_W'(CODE_USE);
                pacer_clear = m_ack;
            end
            ST_GRANT_RD: begin
                m_req      = 1'b1;
                m_addr     = A_ACCESS;
                pacer_miss = m_ack && !active_seen && !last_poll;
            end
            ST_GRANT_GAP: begin
            end
            ST_CMD_WR: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_addr  = A_STATUS;
                m_wdata = DATA_W'(CODE_CMDRDY);
            end
            ST_CHK_RD: begin
                m_req  = 1'b1;
                m_addr = A_ACCESS;
            end
            ST_REL_WR: begin
                m_req       = 1'b1;
                m_we        = 1'b1;
                m_addr      = A_ACCESS;
                m_wdata     = DATA_W'(CODE_RELEASE);
                pacer_clear = m_ack;
            end
            ST_REL_RD: begin
                m_req      = 1'b1;
                m_addr     = A_ACCESS;
                pacer_miss = m_ack && active_seen && !last_poll;
            end
            ST_REL_GAP: begin
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/tis_locality_chk.sv
module tis_locality_chk
    import tis_locality_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned REG_BASE = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              ready,
    input logic              err_nodev,
    input logic              err_timeout,
    input logic              m_req,
    input logic              m_we,
    input logic [ADDR_W-1:0] m_addr,
    input logic [DATA_W-1:0] m_wdata,
    input logic              m_ack
);
    localparam logic [ADDR_W-1:0] C_ACCESS = ADDR_W'(REG_BASE + OFS_ACCESS);
    localparam logic [ADDR_W-1:0] C_STATUS = ADDR_W'(REG_BASE + OFS_STATUS);
    localparam logic [ADDR_W-1:0] C_IDENT  = ADDR_W'(REG_BASE + OFS_IDENT);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_we) && $stable(m_addr) && $stable(m_wdata)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_req);

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ready, err_nodev, err_timeout}));

    // R4
    ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(m_req && m_ack && m_we && m_addr == C_STATUS));

    // R2
    nodev_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_nodev) |-> $past(m_req && m_ack && !m_we && m_addr == C_IDENT));

    // R6
    timeout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> $past(m_req && m_ack && !m_we && m_addr == C_ACCESS));

    // R3
    legal_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we) |-> (m_wdata == DATA_W'(CODE_USE) || m_wdata == DATA_W'(CODE_RELEASE)
                             || m_wdata == DATA_W'(CODE_CMDRDY)));
endmodule

bind tis_locality_ctrl tis_locality_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_BASE (REG_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .ready       (ready),
    .err_nodev   (err_nodev),
    .err_timeout (err_timeout),
    .m_req       (m_req),
    .m_we        (m_we),
    .m_addr      (m_addr),
    .m_wdata     (m_wdata),
    .m_ack       (m_ack)
);

// File: tb/tb_tis_locality_ctrl.sv
module tb_tis_locality_ctrl;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 32;
    localparam logic [31:0] GOOD_ID = 32'h3204_1114;
    localparam int unsigned GAP    = 3;
    localparam int unsigned MAXP   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              open_req = 1'b0;
    logic              close_req = 1'b0;
    logic              busy, ready, err_nodev, err_timeout;
    logic              m_req, m_we;
    logic [ADDR_W-1:0] m_addr;
    logic [DATA_W-1:0] m_wdata;
    logic              m_ack = 1'b0;
    logic [DATA_W-1:0] m_rdata = '0;

    int errors = 0;
    int checks = 0;
    longint cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tis_locality_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_BASE(0),
        .EXPECTED_ID(GOOD_ID), .POLL_GAP(GAP), .MAX_POLLS(MAXP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .open_req(open_req), .close_req(close_req),
        .busy(busy), .ready(ready), .err_nodev(err_nodev), .err_timeout(err_timeout),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_rdata(m_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Device model: programmable identity, grant delay and release delay
    logic [31:0] dev_id = GOOD_ID;
    bit          dev_active = 0;
    int          grant_polls = 0;   // -1 means never granted
    int          rel_polls = 0;     // -1 means never released
    int          pend_on = -2;
    int          pend_off = -2;
    int          lat = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ack <= 1'b0;
            lat = 0;
        end else if (m_req && !m_ack) begin
            if (lat == 1) begin
                lat = 0;
                m_ack <= 1'b1;
                m_rdata <= '0;
                if (m_we && m_addr == 16'h0000) begin
                    if (m_wdata == 32'h02 && !dev_active) pend_on = grant_polls;
                    if (m_wdata == 32'h20 && dev_active) pend_off = rel_polls;
                end else if (!m_we && m_addr == 16'h0F00) begin
                    m_rdata <= dev_id;
                end else if (!m_we && m_addr == 16'h0000) begin
                    if (pend_on > 0) pend_on--;
                    else if (pend_on == 0) begin dev_active = 1; pend_on = -2; end
                    if (pend_off > 0) pend_off--;
                    else if (pend_off == 0) begin dev_active = 0; pend_off = -2; end
                    m_rdata <= {26'd0, dev_active, 5'd0};
                end
            end else begin
                lat++;
            end
        end else begin
            m_ack <= 1'b0;
            lat = 0;
        end
    end

    // Reference transfer list: {we, addr, wdata}, compared at every acknowledged transfer
    logic [48:0] exp_q[$];
    string       cur_req = "R1";
    longint      last_rd_cyc = -1;
    bit          prev_acc_rd = 0;

    always @(posedge clk) begin
        if (rst_n && m_req && m_ack) begin
            if (exp_q.size() == 0) begin
                check({cur_req, " unexpected transfer"}, {15'd0, m_we, m_addr, m_wdata}, 64'h0);
            end else begin
                check(cur_req, {15'd0, m_we, m_addr, m_wdata}, {15'd0, exp_q.pop_front()});
            end
            if (!m_we && m_addr == 16'h0000) begin
                if (prev_acc_rd)  // R5 spacing between consecutive polls
                    check("R5 poll spacing ok", 64'(cyc - last_rd_cyc > longint'(GAP)), 64'd1);
                prev_acc_rd = 1;
                last_rd_cyc = cyc;
            end else begin
                prev_acc_rd = 0;
            end
        end
    end

    function automatic logic [48:0] rd(input logic [15:0] a);
        return {1'b0, a, 32'd0};
    endfunction
    function automatic logic [48:0] wr(input logic [15:0] a, input logic [31:0] d);
        return {1'b1, a, d};
    endfunction

    task automatic pulse(input bit o, input bit c);
        @(negedge clk);
        open_req = o; close_req = c;
        @(negedge clk);
        open_req = 0; close_req = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        if (busy) check("watchdog busy stuck", 64'd1, 64'd0);
        @(negedge clk);
    endtask

    task automatic expect_open_ok(input int g);
        exp_q.push_back(rd(16'h0F00));
        exp_q.push_back(wr(16'h0000, 32'h02));
        for (int i = 0; i <= g; i++) exp_q.push_back(rd(16'h0000));
        exp_q.push_back(wr(16'h0018, 32'h40));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check("watchdog expired", 64'd1, 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 flags", {ready, err_nodev, err_timeout}, 0);
        check("R1 m_req", m_req, 0);

        // R2 identity mismatch
        cur_req = "R2";
        dev_id = 32'hDEAD_0001;
        exp_q.push_back(rd(16'h0F00));
        pulse(1, 0);
        wait_idle();
        check("R2 err_nodev", err_nodev, 1);
        check("R2 ready", ready, 0);
        check("R2 queue drained", exp_q.size(), 0);
        repeat (20) @(negedge clk);
        check("R10 err_nodev held", err_nodev, 1);

        // R3 R4 R9 open with grant after two polls, extra requests while busy
        cur_req = "R3/R4";
        dev_id = GOOD_ID;
        grant_polls = 2;
        expect_open_ok(2);
        pulse(1, 0);
        check("R10 flag cleared by new open", err_nodev, 0);
        repeat (3) @(negedge clk);
        pulse(0, 1);
        pulse(1, 0);
        wait_idle();
        check("R4 ready", ready, 1);
        check("R4 queue drained", exp_q.size(), 0);
        cur_req = "R9";
        repeat (30) @(negedge clk);
        check("R9 ignored requests: still ready", ready, 1);
        check("R9 ignored requests: idle", busy, 0);

        // R7 close while held
        cur_req = "R7";
        rel_polls = 1;
        exp_q.push_back(rd(16'h0000));
        exp_q.push_back(wr(16'h0000, 32'h20));
        exp_q.push_back(rd(16'h0000));
        exp_q.push_back(rd(16'h0000));
        pulse(0, 1);
        wait_idle();
        check("R7 ready cleared", ready, 0);
        check("R7 no error", {err_nodev, err_timeout}, 0);
        check("R7 queue drained", exp_q.size(), 0);

        // R8 close while free
        cur_req = "R8";
        exp_q.push_back(rd(16'h0000));
        pulse(0, 1);
        wait_idle();
        repeat (10) @(negedge clk);
        check("R8 queue drained", exp_q.size(), 0);
        check("R8 no flags", {ready, err_nodev, err_timeout}, 0);

        // R6 grant never comes
        cur_req = "R6";
        grant_polls = -1;
        exp_q.push_back(rd(16'h0F00));
        exp_q.push_back(wr(16'h0000, 32'h02));
        for (int i = 0; i < int'(MAXP); i++) exp_q.push_back(rd(16'h0000));
        pulse(1, 0);
        wait_idle();
        repeat (10) @(negedge clk);
        check("R6 err_timeout", err_timeout, 1);
        check("R6 ready", ready, 0);
        check("R6 queue drained", exp_q.size(), 0);

        // R9 simultaneous open and close: open wins, grant on first poll
        cur_req = "R9";
        grant_polls = 0;
        pend_on = -2;
        expect_open_ok(0);
        pulse(1, 1);
        wait_idle();
        check("R9 open priority ready", ready, 1);
        check("R10 timeout cleared", err_timeout, 0);
        check("R9 queue drained", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule